// File: doc/BRIEF.md
# Multipass Quad Batch Scheduler

The scheduler gathers 2x2 pixel quads, each with a tag and a 4-bit coverage mask, into a batch. Per-quad temporary state sits in a fixed state buffer, so the number of quads a batch may hold depends on the bound shader's temporary count and precision. A batch closes when it is full or when the input has been quiet for a programmable number of cycles. The block then runs the shader pass-major: pass 0 for every quad in the batch, then pass 1 for every quad, and so on. Before a pass starts, every result of the previous pass has returned. As a result, a texture fetch issued in one pass has a whole batch worth of cycles to complete before the next pass uses it.

Quads go to a set of identical shader units in strict rotation. Each unit is modelled as a fixed-latency pipeline that adds a per-pass term to four 8-bit lane accumulators. Pixels outside the triangle are shaded like the others. Their lanes are forced to zero when the finished quad leaves. Finished quads leave on a valid/ready port in the order they arrived.

Top module: `quad_batch_sched`

## Requirements
- R1: After reset, in_ready is 1, and out_valid and issue_valid are 0.
- R2: When cfg_load is seen with an empty batch, the capacity becomes floor(STATE_WORDS / (t × w)). Here t is cfg_temps, with 0 read as 1, and w is 1 when cfg_half is 1 and 2 otherwise. The capacity is never below 1. The batch closes on the accept that fills it, and in_ready is 0 in the next cycle.
- R3: Issues go to units 0, 1, …, NUM_UNITS-1, 0, … in strict rotation. The first issue after reset goes to unit 0, and the rotation carries across passes and batches.
- R4: For a batch of n quads and P passes, the issue stream is n×P issues long. Issue k carries issue_slot = k mod n and issue_pass = k div n, so every quad runs a pass before any quad runs the next one.
- R5: A batch that is not full closes after idle_limit consecutive cycles without an accepted quad, with 0 read as 1. The first issue is visible idle_limit+1 cycles after the cycle in which the last quad was accepted.
- R6: cfg_passes = n binds n passes, with 0 read as 1. Pass p adds (tag + p + l) mod 256 to lane l. A finished lane therefore holds the sum over p of (tag + p + l), mod 256.
- R7: Lane l of out_lanes, at bits [8l+7:8l], reads 0 when bit l of the quad's coverage mask is 0.
- R8: Finished quads leave in arrival order with their tag and coverage mask, one per out_valid && out_ready.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_tag, out_cover and out_lanes hold. in_ready is 0 from the moment a batch closes until its last quad has left.
- R10: cfg_load has no effect unless the block is collecting and holds no quad. A rejected bind changes neither the pass count nor the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Bind a shader (sample the cfg_* fields) |
| cfg_temps | input | 4 | Temporaries per quad |
| cfg_half | input | 1 | 1: half-precision temporaries |
| cfg_passes | input | 4 | Pass count of the shader |
| idle_limit | input | TMO_W | Idle cycles that close a partial batch |
| in_valid | input | 1 | Quad offered |
| in_ready | output | 1 | Quad accepted when valid and ready |
| in_tag | input | TAG_W | Quad tag |
| in_cover | input | 4 | Pixel coverage mask |
| issue_valid | output | 1 | A quad is dispatched this cycle |
| issue_unit | output | U_W | Target shader unit |
| issue_pass | output | 4 | Pass being dispatched |
| issue_slot | output | SI_W | Batch slot being dispatched |
| out_valid | output | 1 | Finished quad available |
| out_ready | input | 1 | Consumer takes the finished quad |
| out_tag | output | TAG_W | Tag of the finished quad |
| out_cover | output | 4 | Coverage mask of the finished quad |
| out_lanes | output | 32 | Four 8-bit lane results, masked |

## Verification
Batches are driven that close by capacity and by timeout, for several temporary counts and both precisions. This separates a wrong capacity formula from a wrong closing rule. Multi-pass batches are run with coverage masks from all-clear to all-set. The lane sums expose a pass that is skipped, repeated or started before the previous one returned, and a coverage mask that is not applied. The issue stream is recorded and compared against the pass-major order and the unit rotation. Backpressure on the output and a bind attempted while a quad is held show that held state is neither lost nor overwritten.

// File: rtl/quad_batch_sched.sv
module quad_batch_sched #(
  parameter int NUM_UNITS   = 6,
  parameter int LAT         = 4,
  parameter int STATE_WORDS = 64,
  parameter int TAG_W       = 8,
  parameter int TMO_W       = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_load,
  input  logic [3:0]                       cfg_temps,
  input  logic                             cfg_half,
  input  logic [3:0]                       cfg_passes,
  input  logic [TMO_W-1:0]                 idle_limit,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [TAG_W-1:0]                 in_tag,
  input  logic [3:0]                       in_cover,
  output logic                             issue_valid,
  output logic [$clog2(NUM_UNITS)-1:0]     issue_unit,
  output logic [3:0]                       issue_pass,
  output logic [$clog2(STATE_WORDS)-1:0]   issue_slot,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [TAG_W-1:0]                 out_tag,
  output logic [3:0]                       out_cover,
  output logic [31:0]                      out_lanes
);
  localparam int SLOTS = STATE_WORDS;
  localparam int SI_W  = $clog2(SLOTS);
  localparam int IDX_W = $clog2(SLOTS + 1);
  localparam int U_W   = $clog2(NUM_UNITS);
  localparam logic [IDX_W-1:0] CAP0 = IDX_W'(SLOTS / 2);

  typedef enum logic [1:0] {S_COLLECT, S_RUN, S_WAIT, S_OUT} st_t;
  st_t st;

  logic [IDX_W-1:0] cnt, cap, ptr, inflight, cap_new, cap_eff;
  logic [3:0]       last_pass, pass;
  logic [TMO_W-1:0] idle;
  logic [U_W-1:0]   rr;
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [3:0]       cov_q [SLOTS];
  logic [31:0]      acc_q [SLOTS];

  logic                  bind_ok, accept, wb_v;
  logic [SI_W-1:0]       wb_ix;
  logic [NUM_UNITS-1:0]  u_wb_v;
  logic [SI_W-1:0]       u_wb_ix [NUM_UNITS];
  logic [TMO_W:0]        lim_eff;

  assign in_ready    = (st == S_COLLECT);
  assign accept      = in_valid && in_ready;
  assign bind_ok     = cfg_load && (st == S_COLLECT) && (cnt == '0);
  assign lim_eff     = (idle_limit == '0) ? (TMO_W+1)'(1) : {1'b0, idle_limit};
  assign issue_valid = (st == S_RUN);
  assign issue_unit  = rr;
  assign issue_pass  = pass;
  assign issue_slot  = ptr[SI_W-1:0];
  assign out_valid   = (st == S_OUT);
  assign out_tag     = tag_q[ptr[SI_W-1:0]];
  assign out_cover   = cov_q[ptr[SI_W-1:0]];

  always_comb begin
    for (int l = 0; l < 4; l++)
      out_lanes[8*l +: 8] = out_cover[l] ? acc_q[ptr[SI_W-1:0]][8*l +: 8] : 8'd0;
  end

  always_comb begin
    int t, w, q;
    t = (cfg_temps == 4'd0) ? 1 : int'(cfg_temps);
    w = cfg_half ? 1 : 2;
    q = STATE_WORDS / (t * w);
    if (q < 1) q = 1;
    cap_new = IDX_W'(q);
  end
  assign cap_eff = bind_ok ? cap_new : cap;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic [LAT-1:0]  v;
    logic [SI_W-1:0] ix [LAT];
    always_ff @(posedge clk) begin
      if (!rst_n) v <= '0;
      else        v <= {v[LAT-2:0], issue_valid && (rr == U_W'(g))};
    end
    always_ff @(posedge clk) begin
      ix[0] <= issue_slot;
      for (int s = 1; s < LAT; s++) ix[s] <= ix[s-1];
    end
    assign u_wb_v[g]  = v[LAT-1];
    assign u_wb_ix[g] = ix[LAT-1];
  end

  always_comb begin
    wb_v  = |u_wb_v;
    wb_ix = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (u_wb_v[u]) wb_ix = u_wb_ix[u];
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q[cnt[SI_W-1:0]] <= in_tag;
      cov_q[cnt[SI_W-1:0]] <= in_cover;
      acc_q[cnt[SI_W-1:0]] <= '0;
    end else if (wb_v) begin
      for (int l = 0; l < 4; l++)
        acc_q[wb_ix][8*l +: 8] <= acc_q[wb_ix][8*l +: 8] + 8'(tag_q[wb_ix])
                                  + 8'(pass) + 8'(l);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + IDX_W'(issue_valid) - IDX_W'(wb_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_COLLECT; cnt <= '0; cap <= CAP0; ptr <= '0;
      last_pass <= '0; pass <= '0; idle <= '0; rr <= '0;
    end else begin
      case (st)
        S_COLLECT: begin
          if (bind_ok) begin
            cap       <= cap_new;
            last_pass <= (cfg_passes == 4'd0) ? 4'd0 : cfg_passes - 4'd1;
          end
          if (accept) begin
            cnt  <= cnt + IDX_W'(1);
            idle <= '0;
            if (cnt + IDX_W'(1) == cap_eff) begin
              st <= S_RUN; ptr <= '0; pass <= '0;
            end
          end else if (cnt != '0) begin
            if ({1'b0, idle} + (TMO_W+1)'(1) >= lim_eff) begin
              st <= S_RUN; ptr <= '0; pass <= '0; idle <= '0;
            end else begin
              idle <= idle + TMO_W'(1);
            end
          end
        end
        S_RUN: begin
          rr  <= (rr == U_W'(NUM_UNITS-1)) ? '0 : rr + U_W'(1);
          ptr <= ptr + IDX_W'(1);
          if (ptr == cnt - IDX_W'(1)) st <= S_WAIT;
        end
        S_WAIT: begin
          if (inflight == '0) begin
            ptr <= '0;
            if (pass == last_pass) st <= S_OUT;
            else begin pass <= pass + 4'd1; st <= S_RUN; end
          end
        end
        default: begin
          if (out_ready) begin
            ptr <= ptr + IDX_W'(1);
            if (ptr == cnt - IDX_W'(1)) begin
              st <= S_COLLECT; cnt <= '0; ptr <= '0; idle <= '0;
            end
          end
        end
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> cnt < cap_eff);
  p_rr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid)) |->
      issue_unit == (($past(issue_unit) == U_W'(NUM_UNITS-1)) ? '0 : $past(issue_unit) + U_W'(1)));
  p_pass_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid)) |->
      (issue_pass == $past(issue_pass) && issue_slot == $past(issue_slot) + SI_W'(1)));
  p_wb_tracked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> inflight != '0);
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_lanes)));
  p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!in_ready && !issue_valid));
endmodule

// File: tb/test_quad_batch_sched.sv
module test_quad_batch_sched;
  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, cfg_half = 0;
  logic [3:0] cfg_temps = 4'd1, cfg_passes = 4'd1;
  logic [7:0] idle_limit = 8'd5;
  logic in_valid = 0, out_ready = 1;
  logic [7:0] in_tag = '0;
  logic [3:0] in_cover = '0;
  logic in_ready, issue_valid, out_valid;
  logic [2:0] issue_unit;
  logic [3:0] issue_pass, out_cover;
  logic [5:0] issue_slot;
  logic [7:0] out_tag;
  logic [31:0] out_lanes;

  quad_batch_sched i_quad_batch_sched (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0;
  int out_cnt = 0, iss_cnt = 0, exp_rr = 0, rr_bad = 0;
  logic [7:0]  o_tag [512];
  logic [3:0]  o_cov [512];
  logic [31:0] o_lan [512];
  logic [3:0]  i_pass [2048];
  logic [5:0]  i_slot [2048];
  int          i_cyc [2048];

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(negedge clk); #2;
    if (rst_n && out_valid && out_ready && out_cnt < 512) begin
      o_tag[out_cnt] = out_tag; o_cov[out_cnt] = out_cover; o_lan[out_cnt] = out_lanes;
      out_cnt++;
    end
    if (rst_n && issue_valid && iss_cnt < 2048) begin
      i_pass[iss_cnt] = issue_pass; i_slot[iss_cnt] = issue_slot; i_cyc[iss_cnt] = cyc;
      if (int'(issue_unit) != exp_rr) rr_bad++;
      exp_rr = (exp_rr + 1) % 6;
      iss_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lanes(input logic [7:0] tag, input logic [3:0] cov, input int np);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] s = '0;
      for (int p = 0; p < np; p++) s = s + tag + 8'(p) + 8'(l);
      r[8*l +: 8] = cov[l] ? s : 8'd0;
    end
    return r;
  endfunction

  function automatic logic [3:0] mk(input int i);
    return 4'(i * 5 + 0);
  endfunction

  task automatic bind_cfg(input int t, input bit h, input int p);
    @(negedge clk);
    cfg_load = 1; cfg_temps = 4'(t); cfg_half = h; cfg_passes = 4'(p);
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic send(input logic [7:0] tag, input logic [3:0] cov, output bit stalled);
    stalled = 0;
    @(negedge clk);
    in_valid = 1; in_tag = tag; in_cover = cov;
    while (!in_ready) begin stalled = 1; @(negedge clk); end
    acc_cyc = cyc;
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_out(input int target);
    while (out_cnt < target) @(negedge clk);
  endtask

  task automatic check_batch(input int ostart, input int istart, input int n, input int np,
                             input int base, input string req);
    chk(out_cnt - ostart == n, {req, " R8 count"}, out_cnt - ostart, n);
    for (int i = 0; i < n; i++) begin
      chk(o_tag[ostart+i] == 8'(base+i), "R8 order", o_tag[ostart+i], base + i);
      chk(o_cov[ostart+i] == mk(i), "R8 mask", o_cov[ostart+i], mk(i));
      chk(o_lan[ostart+i] == exp_lanes(8'(base+i), mk(i), np), "R6 R7 lanes",
          o_lan[ostart+i], exp_lanes(8'(base+i), mk(i), np));
    end
    chk(iss_cnt - istart == n * np, "R4 issue count", iss_cnt - istart, n * np);
    for (int k = 0; k < n * np && istart + k < iss_cnt; k++) begin
      chk(int'(i_slot[istart+k]) == k % n, "R4 slot order", i_slot[istart+k], k % n);
      chk(int'(i_pass[istart+k]) == k / n, "R4 pass order", i_pass[istart+k], k / n);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(issue_valid == 0, "R1 issue_valid", issue_valid, 0);
  endtask

  task automatic t_capacity(input int t, input bit h, input int cap, input int base);
    int os, is, st_cnt;
    bit s;
    bind_cfg(t, h, 1);
    os = out_cnt; is = iss_cnt; st_cnt = 0;
    for (int i = 0; i < cap; i++) begin
      send(8'(base+i), mk(i), s);
      if (s) st_cnt++;
    end
    @(negedge clk);
    chk(in_ready == 0, "R2 closes at capacity", in_ready, 0);
    chk(st_cnt == 0, "R2 no stall below capacity", st_cnt, 0);
    in_valid = 0;
    wait_out(os + cap);
    repeat (3) @(negedge clk);
    check_batch(os, is, cap, 1, base, "R2");
  endtask

  task automatic t_timeout(input int lim, input int n, input int np);
    int os, is;
    bit s;
    idle_limit = 8'(lim);
    bind_cfg(1, 0, np);
    os = out_cnt; is = iss_cnt;
    for (int i = 0; i < n; i++) send(8'(40+i), mk(i), s);
    stop_in();
    wait_out(os + n);
    repeat (3) @(negedge clk);
    begin
      int eff = (lim == 0) ? 1 : lim;
      chk(i_cyc[is] - acc_cyc == eff + 1, "R5 idle close", i_cyc[is] - acc_cyc, eff + 1);
    end
    check_batch(os, is, n, (np == 0) ? 1 : np, 40, "R5");
    idle_limit = 8'd5;
  endtask

  task automatic t_backpressure();
    int os, is;
    logic [7:0] t0;
    logic [31:0] l0;
    bit s;
    bind_cfg(2, 0, 2);
    out_ready = 0;
    os = out_cnt; is = iss_cnt;
    for (int i = 0; i < 3; i++) send(8'(90+i), mk(i), s);
    stop_in();
    while (!out_valid) @(negedge clk);
    t0 = out_tag; l0 = out_lanes;
    repeat (5) @(negedge clk);
    chk(out_valid == 1, "R9 valid held", out_valid, 1);
    chk(out_tag == t0, "R9 tag held", out_tag, t0);
    chk(out_lanes == l0, "R9 lanes held", out_lanes, l0);
    chk(in_ready == 0, "R9 input closed", in_ready, 0);
    chk(out_cnt == os, "R9 nothing taken", out_cnt, os);
    out_ready = 1;
    wait_out(os + 3);
    repeat (3) @(negedge clk);
    check_batch(os, is, 3, 2, 90, "R9");
  endtask

  task automatic t_bind_ignored();
    int os, is, st_cnt;
    bit s;
    idle_limit = 8'd30;
    bind_cfg(1, 0, 2);
    os = out_cnt; is = iss_cnt;
    send(8'd120, mk(0), s);
    stop_in();
    bind_cfg(0, 1, 7);
    wait_out(os + 1);
    repeat (3) @(negedge clk);
    check_batch(os, is, 1, 2, 120, "R10");
    idle_limit = 8'd5;
    os = out_cnt; is = iss_cnt; st_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      send(8'(150+i), mk(i), s);
      if (s) st_cnt++;
    end
    @(negedge clk);
    chk(in_ready == 0, "R10 capacity kept at 32", in_ready, 0);
    chk(st_cnt == 0, "R10 no early close", st_cnt, 0);
    in_valid = 0;
    wait_out(os + 32);
    repeat (3) @(negedge clk);
    check_batch(os, is, 32, 2, 150, "R10");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_capacity(3, 0, 10, 0);
        t_capacity(3, 1, 21, 16);
        t_capacity(0, 1, 64, 64);
        t_capacity(15, 0, 2, 200);
        t_timeout(5, 3, 3);
        t_timeout(0, 2, 0);
        t_timeout(9, 7, 4);
        t_backpressure();
        t_bind_ignored();
        chk(rr_bad == 0, "R3 unit rotation", rr_bad, 0);
        chk(iss_cnt > 6, "R3 rotation exercised", iss_cnt, 7);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule